// File: doc/BRIEF.md
# Serial Sampling-Converter Frame and Power Controller

This block is the digital control side of a 12-bit sampling converter whose result is read over a three-wire serial link. The host drives an active-low frame select and a serial clock. Both are sampled in the local clock domain, and every frame is sequenced from their edges. A frame begins when the select falls. At that point the block latches the word offered by the converter core, switches the sampler into hold, and enables its data output. It then presents one bit per falling serial-clock edge: a run of zero bits, followed by the result with the most significant bit first.

The block also decides the power mode. The decision depends only on how many falling serial-clock edges have been seen when the select rises:

- A very early rise leaves the mode unchanged.
- A rise in the middle band puts the block to sleep.
- Reaching the tenth falling edge keeps it awake, or wakes it.

The frame that wakes the block carries an unusable result. A result-valid flag therefore stays low until a complete frame has been read while the block was already awake.

Top module: `sadc_ctrl`

## Requirements
- R1: After reset, sdata_oe, sdata, hold, powered and result_valid are all 0.
- R2: One local clock after the falling edge of cs_n is seen, sdata_oe is 1, hold is 1 and sdata is 0 (frame position 0).
- R3: Frame position p (0 to 15) is driven from the start of the frame or after the p-th falling sclk edge. Positions 0 to 3 are 0, and position p from 4 to 15 carries bit 15-p of the word latched at the falling edge of cs_n. Later changes of conv_word do not affect the frame. sdata changes only on falling sclk edges, and while sdata_oe is 0, sdata is 0.
- R4: hold stays 1 through the 12th rising sclk edge of a frame and returns to 0 on the 13th.
- R5: On the 16th falling sclk edge, sdata_oe returns to 0.
- R6: When cs_n rises during a frame, sdata_oe and hold return to 0 on the next local clock.
- R7: When cs_n rises after fewer than 2 falling sclk edges, powered keeps its value.
- R8: When cs_n rises after 2 to 9 falling sclk edges, powered and result_valid go to 0.
- R9: On the 10th falling sclk edge of a frame, powered becomes 1. It stays 1 when cs_n rises after 10 to 15 falling edges.
- R10: On the 16th falling edge, result_valid takes 1 only if powered was 1 when the frame started; otherwise it takes 0. It changes at no other time except as given in R8.
- R11: sclk edges after the 16th falling edge, and any sclk edges while cs_n is high, leave sdata_oe, sdata, hold and powered unchanged until cs_n rises and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from host |
| sclk | input | 1 | Host serial clock |
| conv_word | input | 12 | Result word offered by the converter core |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Output enable for the data pin (0 = high impedance) |
| hold | output | 1 | 1 while the sampler holds, 0 while it tracks |
| powered | output | 1 | 1 in normal mode, 0 in shutdown |
| result_valid | output | 1 | Last complete frame carried a usable result |

## Verification
The assertions check rules that hold on every cycle:

- the output enable and hold open only on a select fall;
- a select rise closes the output;
- data moves only on falling serial-clock edges and is 0 when disabled;
- the edge count stays bounded;
- the power mode drops only on a select rise, and the drop clears result-valid;
- result-valid rises only on a completed frame.

The bench scenarios show what those rules cannot:

- the exact bit sequence against the latched word;
- the 13th-rise return to track;
- the band boundaries at 2, 9 and 10 falling edges;
- the invalid wake frame followed by a valid one;
- immunity to extra clocking.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    RISE_KEEP,
    RISE_SLEEP,
    RISE_STAY_ON
  } rise_cls_e;

  // Bit presented at frame position pos: lead zeros, then word MSB first.
  function automatic logic frame_bit(input int unsigned pos,
                                     input int unsigned lead,
                                     input int unsigned dw,
                                     input logic [31:0] word);
    logic [31:0] sh;
    if (pos < lead || pos >= lead + dw) return 1'b0;
    sh = word >> (dw - 1 - (pos - lead));
    return sh[0];
  endfunction

  // Effect of a select rise given the falling edges seen so far.
  function automatic rise_cls_e classify_rise(input int unsigned falls,
                                              input int unsigned sleep_from,
                                              input int unsigned wake_at);
    if (falls < sleep_from) return RISE_KEEP;
    if (falls < wake_at) return RISE_SLEEP;
    return RISE_STAY_ON;
  endfunction

endpackage

// File: rtl/sadc_edge.sv
module sadc_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= din;
  end

  assign rise = din & ~prev_q;
  assign fall = ~din & prev_q;
endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
  import sadc_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int LEAD_BITS = 4,
  localparam int FRAME_EDGES = LEAD_BITS + DATA_W,
  localparam int HOLD_RISE   = DATA_W + 1,
  localparam int CNT_W       = $clog2(FRAME_EDGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] conv_word,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              hold,
  output logic              in_frame,
  output logic [CNT_W-1:0]  fall_cnt,
  output logic              fall_taken,
  output logic              frame_done
);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_EDGES - 1);
  localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(HOLD_RISE - 1);

  logic [DATA_W-1:0] word_q;
  logic [CNT_W-1:0]  rise_cnt;
  logic [CNT_W-1:0]  nxt_pos;
  logic              rise_taken;

  assign fall_taken = in_frame & sclk_fall & ~cs_rise & ~cs_fall;
  assign rise_taken = in_frame & sclk_rise & hold & ~cs_rise & ~cs_fall;
  assign frame_done = fall_taken & (fall_cnt == LAST_FALL);
  assign nxt_pos    = fall_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      fall_cnt <= '0;
      rise_cnt <= '0;
      word_q   <= '0;
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
      hold     <= 1'b0;
    end else if (cs_fall) begin
      in_frame <= 1'b1;
      fall_cnt <= '0;
      rise_cnt <= '0;
      word_q   <= conv_word;
      sdata    <= frame_bit(0, LEAD_BITS, DATA_W, 32'(conv_word));
      sdata_oe <= 1'b1;
      hold     <= 1'b1;
    end else if (cs_rise) begin
      in_frame <= 1'b0;
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
      hold     <= 1'b0;
    end else begin
      if (rise_taken) begin
        rise_cnt <= rise_cnt + 1'b1;
        if (rise_cnt == LAST_RISE) hold <= 1'b0;
      end
      if (fall_taken) begin
        fall_cnt <= nxt_pos;
        if (frame_done) begin
          in_frame <= 1'b0;
          sdata    <= 1'b0;
          sdata_oe <= 1'b0;
        end else begin
          sdata <= frame_bit(32'(nxt_pos), LEAD_BITS, DATA_W, 32'(word_q));
        end
      end
    end
  end

  p_oe_opens_on_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(cs_fall));
  p_hold_opens_on_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(cs_fall));
  p_idle_data_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);
  p_data_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && $past(sdata_oe) && !$past(sclk_fall) && !$past(cs_fall)) |-> $stable(sdata));
  p_select_rise_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (!sdata_oe && !hold));
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= CNT_W'(FRAME_EDGES));
endmodule

// File: rtl/sadc_power_ctl.sv
module sadc_power_ctl
  import sadc_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int SLEEP_FROM = 2,
  parameter int WAKE_AT    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             in_frame,
  input  logic [CNT_W-1:0] fall_cnt,
  input  logic             fall_taken,
  input  logic             frame_done,
  output logic             powered,
  output logic             result_valid
);
  localparam logic [CNT_W-1:0] WAKE_IDX = CNT_W'(WAKE_AT - 1);

  logic      started_on;
  logic      wake_edge;
  rise_cls_e rise_cls;

  assign wake_edge = fall_taken & (fall_cnt == WAKE_IDX);
  assign rise_cls  = classify_rise(32'(fall_cnt), SLEEP_FROM, WAKE_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      powered      <= 1'b0;
      result_valid <= 1'b0;
      started_on   <= 1'b0;
    end else begin
      if (cs_fall) started_on <= powered;
      if (cs_rise && in_frame && rise_cls == RISE_SLEEP) begin
        powered      <= 1'b0;
        result_valid <= 1'b0;
      end else begin
        if (wake_edge)  powered      <= 1'b1;
        if (frame_done) result_valid <= started_on;
      end
    end
  end

  p_sleep_only_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(powered) |-> $past(cs_rise));
  p_sleep_clears_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(powered) |-> !result_valid);
  p_valid_needs_full_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> ($past(frame_done) && $past(powered)));
  p_wake_only_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powered) |-> $past(fall_taken));
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl #(
  parameter int DATA_W     = 12,
  parameter int LEAD_BITS  = 4,
  parameter int SLEEP_FROM = 2,
  parameter int WAKE_AT    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] conv_word,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              hold,
  output logic              powered,
  output logic              result_valid
);
  localparam int FRAME_EDGES = LEAD_BITS + DATA_W;
  localparam int CNT_W       = $clog2(FRAME_EDGES + 1);

  logic             cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic             in_frame, fall_taken, frame_done;
  logic [CNT_W-1:0] fall_cnt;

  sadc_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .rise(cs_rise), .fall(cs_fall));

  sadc_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sclk_rise), .fall(sclk_fall));

  sadc_frame_seq #(.DATA_W(DATA_W), .LEAD_BITS(LEAD_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .conv_word(conv_word),
    .sdata(sdata), .sdata_oe(sdata_oe), .hold(hold), .in_frame(in_frame),
    .fall_cnt(fall_cnt), .fall_taken(fall_taken), .frame_done(frame_done));

  sadc_power_ctl #(.CNT_W(CNT_W), .SLEEP_FROM(SLEEP_FROM), .WAKE_AT(WAKE_AT)) u_pwr (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .in_frame(in_frame), .fall_cnt(fall_cnt), .fall_taken(fall_taken),
    .frame_done(frame_done), .powered(powered), .result_valid(result_valid));
endmodule

// File: tb/sadc_ctrl_test.sv
module sadc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] conv_word = '0;
  logic        sdata, sdata_oe, hold, powered, result_valid;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  sadc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .conv_word(conv_word),
    .sdata(sdata), .sdata_oe(sdata_oe), .hold(hold), .powered(powered),
    .result_valid(result_valid));

  function automatic logic exp_bit(input logic [11:0] w, input int pos);
    logic [15:0] stream;
    stream = {4'b0000, w};
    return stream[15 - pos];
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_frame(input logic [11:0] w, input int n_falls, input bit release_cs);
    conv_word = w;
    cs_n = 1'b0;
    settle();
    check("R2", "oe at start", sdata_oe, 1);
    check("R2", "hold at start", hold, 1);
    check("R2", "data at start", sdata, 0);
    conv_word = ~w;
    for (int k = 1; k <= n_falls; k++) begin
      sclk = 1'b0;
      settle();
      if (k < 16) begin
        check("R3", $sformatf("bit pos %0d", k), sdata, exp_bit(w, k));
        check("R5", "oe mid frame", sdata_oe, 1);
      end else begin
        check("R5", "oe after last fall", sdata_oe, 0);
        check("R3", "data after last fall", sdata, 0);
      end
      if (k >= 10) check("R9", $sformatf("powered at fall %0d", k), powered, 1);
      sclk = 1'b1;
      settle();
      check("R4", $sformatf("hold at rise %0d", k), hold, (k < 13) ? 1 : 0);
      if (k < 16) check("R3", "bit steady on rise", sdata, exp_bit(w, k));
    end
    if (release_cs) begin
      cs_n = 1'b1;
      settle();
      check("R6", "oe after select rise", sdata_oe, 0);
      check("R6", "hold after select rise", hold, 0);
    end
  endtask

  task automatic toggle_sclk(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; settle();
      sclk = 1'b1; settle();
    end
  endtask

  task automatic t_reset();
    check("R1", "oe", sdata_oe, 0);
    check("R1", "sdata", sdata, 0);
    check("R1", "hold", hold, 0);
    check("R1", "powered", powered, 0);
    check("R1", "valid", result_valid, 0);
  endtask

  task automatic t_wake_frame();
    do_frame(12'hA5C, 16, 1'b0);
    check("R10", "wake frame not valid", result_valid, 0);
    toggle_sclk(3);
    check("R11", "oe after extra clocks", sdata_oe, 0);
    check("R11", "data after extra clocks", sdata, 0);
    check("R11", "hold after extra clocks", hold, 0);
    cs_n = 1'b1; settle();
    check("R11", "powered after late rise", powered, 1);
  endtask

  task automatic t_valid_frame();
    do_frame(12'h3F1, 16, 1'b1);
    check("R10", "awake frame valid", result_valid, 1);
    do_frame(12'hFFF, 16, 1'b1);
    do_frame(12'h001, 16, 1'b1);
  endtask

  task automatic t_truncate();
    do_frame(12'h7E2, 12, 1'b1);
    check("R9", "powered after truncation", powered, 1);
    check("R10", "valid kept after truncation", result_valid, 1);
  endtask

  task automatic t_early_rise_awake();
    do_frame(12'h111, 1, 1'b1);
    check("R7", "powered after early rise", powered, 1);
  endtask

  task automatic t_sleep_at_two();
    do_frame(12'h222, 2, 1'b1);
    check("R8", "powered after rise at 2", powered, 0);
    check("R8", "valid after rise at 2", result_valid, 0);
  endtask

  task automatic t_early_rise_asleep();
    do_frame(12'h333, 1, 1'b1);
    check("R7", "still asleep", powered, 0);
  endtask

  task automatic t_idle_clock();
    toggle_sclk(4);
    check("R11", "oe idle clocking", sdata_oe, 0);
    check("R11", "data idle clocking", sdata, 0);
    check("R11", "hold idle clocking", hold, 0);
    check("R11", "powered idle clocking", powered, 0);
  endtask

  task automatic t_band_edges();
    do_frame(12'h999, 9, 1'b1);
    check("R8", "asleep after rise at 9", powered, 0);
    do_frame(12'h5A5, 10, 1'b1);
    check("R9", "awake after rise at 10", powered, 1);
    check("R10", "valid still low", result_valid, 0);
    do_frame(12'hC3C, 16, 1'b1);
    check("R10", "valid after awake frame", result_valid, 1);
    do_frame(12'h0F0, 5, 1'b1);
    check("R8", "asleep after rise at 5", powered, 0);
    check("R8", "valid cleared at 5", result_valid, 0);
    do_frame(12'h456, 16, 1'b1);
    check("R10", "rewake frame invalid", result_valid, 0);
    do_frame(12'h789, 16, 1'b1);
    check("R10", "second frame valid", result_valid, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_wake_frame();
    t_valid_frame();
    t_truncate();
    t_early_rise_awake();
    t_sleep_at_two();
    t_early_rise_asleep();
    t_idle_clock();
    t_band_edges();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule